// File: doc/BRIEF.md
# Four-Bit ALU with Skip Generation

This block is the 4-bit arithmetic and logic unit of a controller whose conditional flow is built on skipping: instead of raising status flags for a later branch, an operation can assert a skip output that tells the sequencer to discard the next instruction. Each cycle the unit takes an accumulator value, a memory value, an immediate value and a 5-bit operation code. It returns a 4-bit result and a skip indication in the same cycle. The unit owns the carry flag as a register, and the flag changes on the next clock edge.

The operations cover the following:
- Increment and decrement, with detection of the wrap.
- Three add forms, plus an add of an immediate.
- Decimal correction, done as a fixed add of 6 or 10.
- Bitwise logic, one's and two's complement, and rotation through the carry.
- Equality compares.
- Setting, clearing and testing the carry.

Register files, memory addressing and instruction fetch stay with the surrounding sequencer. To increment or decrement a memory word, the sequencer routes that word onto the accumulator input.

Top module: `alu4_skip`

## Requirements
- R1: Code 1 (increment) gives result = (A+1) mod 16 and asserts skip exactly when that result is 0. The carry is unchanged.
- R2: Code 2 (decrement) gives result = (A-1) mod 16 and asserts skip exactly when that result is 0xF. The carry is unchanged.
- R3: Code 3 gives (A+M) mod 16 and code 6 gives (A+IMM) mod 16. Each skips exactly when the 5-bit sum exceeds 15 and leaves the carry unchanged.
- R4: Code 4 and code 5 both give (A+M+C) mod 16 and load C with the carry out on the next edge. Code 4 skips on carry out. Code 5 never skips.
- R5: Code 7 gives (A+6) mod 16 and code 8 gives (A+10) mod 16. Neither skips, and neither changes the carry.
- R6: The following codes never skip and never change the carry:
  - code 9: A AND M
  - code 10: A OR M
  - code 11: A XOR M
  - code 12: NOT A
  - code 13: (NOT A + 1) mod 16
- R7: Code 14 gives {A[2:0],C} and loads C with A[3]. Code 15 gives {C,A[3:1]} and loads C with A[0]. Neither skips.
- R8: Code 16 skips when A = M, code 17 when A = IMM, and code 18 when M = IMM. The result is A and the carry is unchanged.
- R9: Code 19 sets C, code 20 clears C, and code 21 skips when C = 1. All three give result A.
- R10: Synchronous active-low reset clears the carry. Code 0 gives result A, does not skip and keeps the carry. Codes 22 to 31 behave as code 0.
- R11: Skip and result are combinational in the same cycle as the inputs. Only codes 1, 2, 3, 4, 6, 16, 17, 18 and 21 can assert skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 5 | Operation code |
| acc_i | input | 4 | Accumulator operand |
| mem_i | input | 4 | Memory operand |
| imm_i | input | 4 | Immediate operand |
| result_o | output | 4 | Operation result |
| skip_o | output | 1 | Discard-next-instruction request |
| carry_o | output | 1 | Current carry flag |

## Verification
The bench concentrates on the wrap points and on how each add form treats the carry.
- Increment from F and decrement from 0: a design that tested the wrong end would skip on 1 or on E instead.
- Add with carry at sums of exactly 15 and 16: an off-by-one carry would skip one value too early or too late.
- Carry-neutral add forms: a design that let them write the carry would corrupt the next add-with-carry.
- Rotates: swapping in the wrong end bit would show up as a wrong carry on the following cycle.
- Compares: a design that wrote the compare difference to the result, or skipped on inequality, would be caught because every code is swept against every accumulator value.

// File: rtl/alu4_pkg.sv
// Package: shared operation codes for the 4-bit skip ALU.
// Assumes a 5-bit operation field; unlisted codes act as no-operation.
package alu4_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 5'd0,
        OP_INC  = 5'd1,
        OP_DEC  = 5'd2,
        OP_ADDS = 5'd3,
        OP_ADCS = 5'd4,
        OP_ADC  = 5'd5,
        OP_ADDI = 5'd6,
        OP_DAA  = 5'd7,
        OP_DAS  = 5'd8,
        OP_AND  = 5'd9,
        OP_OR   = 5'd10,
        OP_XOR  = 5'd11,
        OP_CPL  = 5'd12,
        OP_NEG  = 5'd13,
        OP_RAL  = 5'd14,
        OP_RAR  = 5'd15,
        OP_CAM  = 5'd16,
        OP_CAI  = 5'd17,
        OP_CMI  = 5'd18,
        OP_SETC = 5'd19,
        OP_CLRC = 5'd20,
        OP_TSTC = 5'd21
    } alu_op_e;
endpackage

// File: rtl/alu4_arith.sv
// Adder path: increment, decrement, the add forms and decimal correction.
// Assumes one shared adder; hit_o is the skip condition of adder operations.
module alu4_arith
    import alu4_pkg::*;
#(
    parameter int W     = 4,
    parameter int DAA_K = 6,
    parameter int DAS_K = 10
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] m_i,
    input  logic [W-1:0] imm_i,
    input  logic         c_i,
    output logic [W-1:0] res_o,
    output logic         cout_o,
    output logic         hit_o,
    output logic         sel_o
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ALL1 = '1;

    logic [W-1:0] b;
    logic         cin;
    logic [W:0]   sum;

    // Select the second adder operand and carry-in per operation.
    always_comb begin
        b     = '0;
        cin   = 1'b0;
        sel_o = 1'b1;
        unique case (op_i)
            OP_INC:         b = ONE;
            OP_DEC:         b = ALL1;
            OP_ADDS:        b = m_i;
            OP_ADCS,
            OP_ADC: begin
                b   = m_i;
                cin = c_i;
            end
            OP_ADDI:        b = imm_i;
            OP_DAA:         b = W'(DAA_K);
            OP_DAS:         b = W'(DAS_K);
            default:        sel_o = 1'b0;
        endcase
    end

    // Shared adder.
    assign sum    = {1'b0, a_i} + {1'b0, b} + {{W{1'b0}}, cin};
    assign res_o  = sum[W-1:0];
    assign cout_o = sum[W];

    // Skip condition for the adder operations.
    always_comb begin
        unique case (op_i)
            OP_INC:                   hit_o = (sum[W-1:0] == '0);
            OP_DEC:                   hit_o = (sum[W-1:0] == ALL1);
            OP_ADDS, OP_ADCS, OP_ADDI: hit_o = sum[W];
            default:                  hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu4_logic.sv
// Bitwise path: AND, OR, XOR, complements and rotation through carry.
// Assumes the carry is supplied by the owner of the flag register.
module alu4_logic
    import alu4_pkg::*;
#(
    parameter int W = 4
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] m_i,
    input  logic         c_i,
    output logic [W-1:0] res_o,
    output logic         rot_c_o,
    output logic         rot_o,
    output logic         sel_o
);
    // Compute bitwise result and the bit rotated out.
    always_comb begin
        res_o   = a_i;
        rot_c_o = 1'b0;
        rot_o   = 1'b0;
        sel_o   = 1'b1;
        unique case (op_i)
            OP_AND: res_o = a_i & m_i;
            OP_OR:  res_o = a_i | m_i;
            OP_XOR: res_o = a_i ^ m_i;
            OP_CPL: res_o = ~a_i;
            OP_NEG: res_o = ~a_i + W'(1);
            OP_RAL: begin
                res_o   = {a_i[W-2:0], c_i};
                rot_c_o = a_i[W-1];
                rot_o   = 1'b1;
            end
            OP_RAR: begin
                res_o   = {c_i, a_i[W-1:1]};
                rot_c_o = a_i[0];
                rot_o   = 1'b1;
            end
            default: sel_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu4_cmp.sv
// Test path: equality compares and the carry test, producing a skip only.
// Assumes compares never alter the result or the carry.
module alu4_cmp
    import alu4_pkg::*;
#(
    parameter int W = 4
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] m_i,
    input  logic [W-1:0] imm_i,
    input  logic         c_i,
    output logic         hit_o
);
    // Evaluate the test selected by the operation.
    always_comb begin
        unique case (op_i)
            OP_CAM:  hit_o = (a_i == m_i);
            OP_CAI:  hit_o = (a_i == imm_i);
            OP_CMI:  hit_o = (m_i == imm_i);
            OP_TSTC: hit_o = c_i;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu4_skip.sv
// Top: 4-bit ALU with skip output and an owned carry flag register.
// Assumes one operation per cycle; result and skip are combinational,
// and the carry updates on the rising edge.
module alu4_skip
    import alu4_pkg::*;
#(
    parameter int W     = 4,
    parameter int DAA_K = 6,
    parameter int DAS_K = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    acc_i,
    input  logic [W-1:0]    mem_i,
    input  logic [W-1:0]    imm_i,
    output logic [W-1:0]    result_o,
    output logic            skip_o,
    output logic            carry_o
);
    alu_op_e      op;
    logic         c_q, c_d;
    logic [W-1:0] ar_res, lg_res;
    logic         ar_cout, ar_hit, ar_sel;
    logic         lg_rc, lg_rot, lg_sel;
    logic         cmp_hit;

    assign op = alu_op_e'(op_i);

    alu4_arith #(.W(W), .DAA_K(DAA_K), .DAS_K(DAS_K)) u_arith (
        .op_i  (op),
        .a_i   (acc_i),
        .m_i   (mem_i),
        .imm_i (imm_i),
        .c_i   (c_q),
        .res_o (ar_res),
        .cout_o(ar_cout),
        .hit_o (ar_hit),
        .sel_o (ar_sel)
    );

    alu4_logic #(.W(W)) u_logic (
        .op_i   (op),
        .a_i    (acc_i),
        .m_i    (mem_i),
        .c_i    (c_q),
        .res_o  (lg_res),
        .rot_c_o(lg_rc),
        .rot_o  (lg_rot),
        .sel_o  (lg_sel)
    );

    alu4_cmp #(.W(W)) u_cmp (
        .op_i (op),
        .a_i  (acc_i),
        .m_i  (mem_i),
        .imm_i(imm_i),
        .c_i  (c_q),
        .hit_o(cmp_hit)
    );

    // Pick the result from the active path; otherwise pass A through.
    always_comb begin
        if (ar_sel)      result_o = ar_res;
        else if (lg_sel) result_o = lg_res;
        else             result_o = acc_i;
    end

    assign skip_o = ar_hit | cmp_hit;

    // Next carry: only carry-writing operations change it.
    always_comb begin
        c_d = c_q;
        if (op == OP_ADCS || op == OP_ADC) c_d = ar_cout;
        else if (lg_rot)                   c_d = lg_rc;
        else if (op == OP_SETC)            c_d = 1'b1;
        else if (op == OP_CLRC)            c_d = 1'b0;
    end

    // Carry flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= 1'b0;
        else        c_q <= c_d;
    end

    assign carry_o = c_q;
endmodule

// File: rtl/alu4_skip_chk.sv
// Checker: temporal properties on the ALU ports, bound to the top module.
module alu4_skip_chk
    import alu4_pkg::*;
#(
    parameter int W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [OP_W-1:0] op_i,
    input logic [W-1:0]    acc_i,
    input logic [W-1:0]    mem_i,
    input logic [W-1:0]    result_o,
    input logic            skip_o,
    input logic            carry_o
);
    logic carry_neutral, may_skip;
    assign carry_neutral = (op_i >= 5'd7 && op_i <= 5'd13) || (op_i >= 5'd16 && op_i <= 5'd18)
                         || op_i == 5'd0 || op_i == 5'd1 || op_i == 5'd2 || op_i == 5'd3
                         || op_i == 5'd6 || op_i == 5'd21 || op_i > 5'd21;
    assign may_skip = (op_i >= 5'd1 && op_i <= 5'd4) || op_i == 5'd6
                    || (op_i >= 5'd16 && op_i <= 5'd18) || op_i == 5'd21;

    AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd1) |-> (skip_o == (result_o == '0))); // R1
    AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd2) |-> (skip_o == (result_o == '1))); // R2
    AST_CMP_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 5'd16 && op_i <= 5'd18) |-> (result_o == acc_i)); // R8
    AST_CARRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        carry_neutral |=> $stable(carry_o)); // R6
    AST_SETC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd19) |=> carry_o); // R9
    AST_CLRC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd20) |=> !carry_o); // R9
    AST_RAL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd14) |=> (carry_o == $past(acc_i[W-1]))); // R7
    AST_SKIP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !may_skip |-> !skip_o); // R11
endmodule

bind alu4_skip alu4_skip_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .acc_i   (acc_i),
    .mem_i   (mem_i),
    .result_o(result_o),
    .skip_o  (skip_o),
    .carry_o (carry_o)
);

// File: tb/tb_alu4_skip.sv
`timescale 1ns/1ps
module tb_alu4_skip;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_i = '0;
    logic [3:0] acc_i = '0, mem_i = '0, imm_i = '0;
    logic [3:0] result_o;
    logic       skip_o, carry_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int model_c = 0;

    always #2.5 clk = ~clk;

    alu4_skip dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i),
        .mem_i(mem_i), .imm_i(imm_i),
        .result_o(result_o), .skip_o(skip_o), .carry_o(carry_o)
    );

    function automatic string tag(input int op);
        case (op)
            1: return "R1";
            2: return "R2";
            3, 6: return "R3";
            4, 5: return "R4";
            7, 8: return "R5";
            9, 10, 11, 12, 13: return "R6";
            14, 15: return "R7";
            16, 17, 18: return "R8";
            19, 20, 21: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Behavioural reference of one operation.
    task automatic model(input int op, input int a, input int m, input int n, input int c,
                         output int res, output int sk, output int nc);
        int s;
        res = a; sk = 0; nc = c;
        case (op)
            1: begin res = (a + 1) % 16; sk = (res == 0); end
            2: begin res = (a + 15) % 16; sk = (res == 15); end
            3: begin s = a + m; res = s % 16; sk = (s > 15); end
            4: begin s = a + m + c; res = s % 16; sk = (s > 15); nc = (s > 15); end
            5: begin s = a + m + c; res = s % 16; nc = (s > 15); end
            6: begin s = a + n; res = s % 16; sk = (s > 15); end
            7: res = (a + 6) % 16;
            8: res = (a + 10) % 16;
            9: res = a & m;
            10: res = a | m;
            11: res = a ^ m;
            12: res = 15 - a;
            13: res = (16 - a) % 16;
            14: begin res = ((a * 2) % 16) + c; nc = a / 8; end
            15: begin res = (a / 2) + c * 8; nc = a % 2; end
            16: sk = (a == m);
            17: sk = (a == n);
            18: sk = (m == n);
            19: nc = 1;
            20: nc = 0;
            21: sk = c;
            default: ;
        endcase
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one operation mid-cycle, compare outputs, then advance the model.
    task automatic step(input int op, input int a, input int m, input int n);
        int er, es, enc;
        @(negedge clk);
        op_i = 5'(op); acc_i = 4'(a); mem_i = 4'(m); imm_i = 4'(n);
        #1;
        model(op, a, m, n, model_c, er, es, enc);
        check(tag(op), "result", int'(result_o), er);
        check(tag(op), "skip", int'(skip_o), es);
        check(tag(op), "carry", int'(carry_o), model_c);
        @(posedge clk);
        model_c = enc;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "reset carry", int'(carry_o), 0);
        rst_n = 1'b1;
        model_c = 0;
        // R1 / R2 wrap points
        step(1, 15, 0, 0); step(1, 7, 0, 0);
        step(2, 0, 0, 0);  step(2, 8, 0, 0);
        // R3 carry-neutral adds at the 15/16 boundary
        step(3, 8, 7, 0);  step(3, 8, 8, 0); step(6, 9, 0, 7);
        // R4 add with carry: sum exactly 16 with carry in
        step(19, 0, 0, 0); step(4, 7, 8, 0); step(5, 15, 0, 0); step(5, 0, 0, 0);
        // R5 decimal correction
        step(7, 12, 0, 0); step(8, 3, 0, 0);
        // R7 rotates
        step(14, 9, 0, 0); step(15, 6, 0, 0); step(15, 1, 0, 0);
        // R8 compares, R9 carry test
        step(16, 5, 5, 0); step(17, 5, 0, 4); step(18, 0, 3, 3);
        step(21, 0, 0, 0); step(20, 0, 0, 0); step(21, 0, 0, 0);
        // R6 / R10 / R11: sweep every code over A and a set of M values
        for (int op = 0; op < 32; op++)
            for (int a = 0; a < 16; a++)
                for (int k = 0; k < 4; k++)
                    step(op, a, (a * 5 + k * 7) % 16, (a + k * 3) % 16);
        // R10 reset clears a set carry
        step(19, 0, 0, 0);
        @(negedge clk); rst_n = 1'b0; op_i = '0;
        @(posedge clk); @(negedge clk);
        check("R10", "carry after reset", int'(carry_o), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule